// File: doc/BRIEF.md
# CORDIC Sine/Cosine Numerically Controlled Oscillator

This block is a direct digital synthesizer. A phase register advances by a programmable frequency word on every enabled clock. A static phase offset is added to it, so that the carrier can be keyed in phase. The resulting phase drives an unrolled rotation-mode CORDIC, which turns it into a cosine and a sine sample. The block accepts a new phase every clock and delivers one cosine/sine pair every clock once the pipeline is full.

The CORDIC is built without a lookup table. The top two phase bits select a quadrant, and the remaining bits form a first-quadrant angle inside the convergence range. One pipeline stage per iteration rotates the vector with fixed, hardwired shifts. The start vector is pre-divided by the CORDIC gain, so the result lands at a fixed amplitude with no multiplier. At the pipeline end, a delayed copy of the quadrant bits swaps and negates the pair. A valid flag travels with each sample, so every output pair is tied to the phase that produced it.

Top module: `cordic_nco`

## Requirements
- R1: While reset is applied and after its release, before any enabled sample arrives, valid_o is 0 and cos_o and sin_o are 0.
- R2: The phase register starts at 0 after reset. Each cycle with en_i high, it advances by fcw_i modulo 2^PHASE_W. In a cycle with en_i low it keeps its value, whatever fcw_i is.
- R3: The phase of an enabled sample is the phase register value of that cycle plus poff_i, modulo 2^PHASE_W. The offset never changes the phase register.
- R4: Each cycle with en_i high produces exactly one output with valid_o high, STAGES+1 clock cycles later. Outputs keep their input order.
- R5: For a sample of phase P, cos_o equals AMP*cos(2*pi*P/2^PHASE_W) and sin_o equals AMP*sin(2*pi*P/2^PHASE_W), each within 4 LSB. AMP is 2^(DATA_W-1) - 2^(DATA_W-6), which is 31744 at the default width.
- R6: Phase bits [PHASE_W-1:PHASE_W-2] select the quadrant. At the four exact quarter-turn phases 0, 2^(PHASE_W-2), 2^(PHASE_W-1) and 3*2^(PHASE_W-2), the output pair is (AMP,0), (0,AMP), (-AMP,0) and (0,-AMP), within 4 LSB.
- R7: For every phase, sqrt(cos_o^2 + sin_o^2) stays within 6 LSB of AMP.
- R8: While valid_o is low, cos_o and sin_o keep the last valid sample.
- R9: The magnitudes of cos_o and sin_o never exceed AMP+4. This holds at phases just below and just above each quadrant boundary, so no output wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Sample enable: take one sample and advance the phase |
| fcw_i | input | PHASE_W | Frequency word, the phase step per enabled cycle |
| poff_i | input | PHASE_W | Phase offset added to the phase register |
| cos_o | output | DATA_W | Cosine sample, two's complement |
| sin_o | output | DATA_W | Sine sample, two's complement |
| valid_o | output | 1 | Sample valid, STAGES+1 cycles after en_i |

## Verification
A wrong micro-rotation constant or shift shows at the ports as a phase-dependent error in amplitude and angle. The magnitude check catches it on the first affected sample, STAGES+1 cycles after the input. A misdecoded quadrant shows as a pair that is swapped or has the wrong sign, most clearly at the exact quarter-turn phases. A fault in the phase register or in the enable gating shifts the phase of every later sample, so the first enabled sample after the fault already disagrees with the reference model. A misaligned valid tag shows as a sample arriving in the wrong cycle, or as a changed output while valid is low.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;

  localparam real TWO_PI = 6.283185307179586;

  function automatic real pow2_neg(input int n);
    real p;
    p = 1.0;
    for (int k = 0; k < n; k++) p = p / 2.0;
    return p;
  endfunction

  // atan(2^-i) as a fraction of a full turn, scaled to pw bits
  function automatic int atan_word(input int i, input int pw);
    real a;
    a = $atan(pow2_neg(i)) / TWO_PI;
    for (int k = 0; k < pw; k++) a = a * 2.0;
    return $rtoi(a + 0.5);
  endfunction

  function automatic real cordic_gain(input int n);
    real g;
    g = 1.0;
    for (int k = 0; k < n; k++) g = g * $sqrt(1.0 + pow2_neg(k) * pow2_neg(k));
    return g;
  endfunction

  // start vector x, pre-divided by the gain, in guard-extended units
  function automatic int start_x(input int amp, input int guard, input int n);
    real v;
    v = amp;
    for (int k = 0; k < guard; k++) v = v * 2.0;
    return $rtoi(v / cordic_gain(n) + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] fcw_i,
  input  logic [PHASE_W-1:0] poff_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_q + fcw_i;
  end

  // offset applied after the register, so it never accumulates
  assign phase_o = acc_q + poff_i;

  // R2
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc_q == $past(acc_q) + $past(fcw_i));

  // R2
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));

endmodule

// File: rtl/nco_quad_fold.sv
module nco_quad_fold
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24
) (
  input  logic                      [PHASE_W-1:0] phase_i,
  output quad_e                                   quad_o,
  output logic signed               [PHASE_W-1:0] z_o
);

  assign quad_o = quad_e'(phase_i[PHASE_W-1 -: 2]);
  // angle inside the quadrant, [0, quarter turn), always inside convergence range
  assign z_o    = {2'b00, phase_i[PHASE_W-3:0]};

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage
  import nco_pkg::*;
#(
  parameter int XW    = 21,
  parameter int ZW    = 24,
  parameter int SHIFT = 0,
  parameter int ATAN  = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  quad_e                quad_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 v_o,
  output quad_e                quad_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  localparam logic signed [ZW-1:0] ANGLE = ZW'(ATAN);
  localparam logic signed [ZW-1:0] QTR   = ZW'(1) <<< (ZW - 3);

  logic signed [XW-1:0] x_sh, y_sh, x_d, y_d;
  logic signed [ZW-1:0] z_d;

  // fixed wiring shift, no barrel shifter
  assign x_sh = x_i >>> SHIFT;
  assign y_sh = y_i >>> SHIFT;

  always_comb begin
    if (!z_i[ZW-1]) begin
      x_d = x_i - y_sh;
      y_d = y_i + x_sh;
      z_d = z_i - ANGLE;
    end else begin
      x_d = x_i + y_sh;
      y_d = y_i - x_sh;
      z_d = z_i + ANGLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      quad_o <= QUAD_0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else begin
      v_o    <= v_i;
      quad_o <= quad_i;
      x_o    <= x_d;
      y_o    <= y_d;
      z_o    <= z_d;
    end
  end

  // R5: residual stays within one eighth of a turn after every micro-rotation
  z_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (z_o <= QTR && z_o >= -QTR));

  // R4
  tag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |=> v_o);

  // R4
  tag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> !v_o);

endmodule

// File: rtl/nco_quad_out.sv
module nco_quad_out
  import nco_pkg::*;
#(
  parameter int XW     = 21,
  parameter int DATA_W = 16,
  parameter int GUARD  = 4,
  parameter int AMP    = 31744
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     v_i,
  input  quad_e                    quad_i,
  input  logic signed [XW-1:0]     x_i,
  input  logic signed [XW-1:0]     y_i,
  output logic                     v_o,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [DATA_W-1:0] sin_o
);

  localparam logic signed [XW-1:0]     RND   = XW'(1) <<< (GUARD - 1);
  localparam logic signed [DATA_W-1:0] LIMIT = DATA_W'(AMP + 4);

  logic signed [XW-1:0]     x_r, y_r;
  logic signed [DATA_W-1:0] c_n, s_n, c_d, s_d;

  assign x_r = (x_i + RND) >>> GUARD;
  assign y_r = (y_i + RND) >>> GUARD;
  assign c_n = x_r[DATA_W-1:0];
  assign s_n = y_r[DATA_W-1:0];

  always_comb begin
    unique case (quad_i)
      QUAD_0: begin c_d =  c_n; s_d =  s_n; end
      QUAD_1: begin c_d = -s_n; s_d =  c_n; end
      QUAD_2: begin c_d = -c_n; s_d = -s_n; end
      default: begin c_d =  s_n; s_d = -c_n; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        cos_o <= c_d;
        sin_o <= s_d;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> ($stable(cos_o) && $stable(sin_o)));

  // R9
  out_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_o <= LIMIT && cos_o >= -LIMIT && sin_o <= LIMIT && sin_o >= -LIMIT));

endmodule

// File: rtl/cordic_nco.sv
module cordic_nco
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int DATA_W  = 16,
  parameter int STAGES  = 16,
  parameter int GUARD   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [PHASE_W-1:0]       fcw_i,
  input  logic [PHASE_W-1:0]       poff_i,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [DATA_W-1:0] sin_o,
  output logic                     valid_o
);

  localparam int XW  = DATA_W + GUARD + 1;
  localparam int AMP = 2 ** (DATA_W - 1) - 2 ** (DATA_W - 6);
  localparam int X0  = start_x(AMP, GUARD, STAGES);

  logic [PHASE_W-1:0]       phase;
  quad_e                    quad_f;
  logic signed [PHASE_W-1:0] z_f;

  logic                      v_s [STAGES+1];
  quad_e                     q_s [STAGES+1];
  logic signed [XW-1:0]      x_s [STAGES+1];
  logic signed [XW-1:0]      y_s [STAGES+1];
  logic signed [PHASE_W-1:0] z_s [STAGES+1];

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .fcw_i  (fcw_i),
    .poff_i (poff_i),
    .phase_o(phase)
  );

  nco_quad_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase_i(phase),
    .quad_o (quad_f),
    .z_o    (z_f)
  );

  assign v_s[0] = en_i;
  assign q_s[0] = quad_f;
  assign x_s[0] = XW'(X0);
  assign y_s[0] = '0;
  assign z_s[0] = z_f;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    nco_cordic_stage #(
      .XW   (XW),
      .ZW   (PHASE_W),
      .SHIFT(i),
      .ATAN (atan_word(i, PHASE_W))
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (v_s[i]),
      .quad_i(q_s[i]),
      .x_i   (x_s[i]),
      .y_i   (y_s[i]),
      .z_i   (z_s[i]),
      .v_o   (v_s[i+1]),
      .quad_o(q_s[i+1]),
      .x_o   (x_s[i+1]),
      .y_o   (y_s[i+1]),
      .z_o   (z_s[i+1])
    );
  end

  nco_quad_out #(
    .XW    (XW),
    .DATA_W(DATA_W),
    .GUARD (GUARD),
    .AMP   (AMP)
  ) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v_s[STAGES]),
    .quad_i(q_s[STAGES]),
    .x_i   (x_s[STAGES]),
    .y_i   (y_s[STAGES]),
    .v_o   (valid_o),
    .cos_o (cos_o),
    .sin_o (sin_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);

endmodule

// File: tb/cordic_nco_test.sv
module cordic_nco_test;

  localparam int    PW      = 24;
  localparam int    DW      = 16;
  localparam int    ST      = 16;
  localparam int    LAT     = ST + 1;
  localparam int    AMP     = 31744;
  localparam int    TOL     = 4;
  localparam int    MAG_TOL = 6;
  localparam real   TWO_PI  = 6.283185307179586;

  typedef struct {
    int unsigned ph;
    int          due;
    int          tag;
  } item_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en = 1'b0;
  logic [PW-1:0]        fcw = '0;
  logic [PW-1:0]        poff = '0;
  logic signed [DW-1:0] cos_w, sin_w;
  logic                 valid_w;

  item_t         sb[$];
  logic [PW-1:0] model_acc = '0;
  int            cyc = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  int            last_c = 0, last_s = 0;
  bit            seen = 1'b0;
  bit            done = 1'b0;

  cordic_nco #(.PHASE_W(PW), .DATA_W(DW), .STAGES(ST), .GUARD(4)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .fcw_i  (fcw),
    .poff_i (poff),
    .cos_o  (cos_w),
    .sin_o  (sin_w),
    .valid_o(valid_w)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // driver: one cycle of stimulus, expected item pushed when enabled
  task automatic drive(input bit e, input logic [PW-1:0] f, input logic [PW-1:0] o, input int tag);
    @(negedge clk);
    en   = e;
    fcw  = f;
    poff = o;
    if (e) begin
      logic [PW-1:0] p;
      p = model_acc + o;
      sb.push_back('{ph: int'(p), due: cyc + LAT, tag: tag});
      model_acc = model_acc + f;
    end
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // monitor
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      if (valid_w) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected valid", 1, 0);
        end else begin
          item_t it;
          real   th, m;
          int    ec, es, c, s;
          string rq;
          it = sb.pop_front();
          c  = int'(cos_w);
          s  = int'(sin_w);
          th = TWO_PI * real'(it.ph) / real'(2.0 ** PW);
          ec = int'(real'(AMP) * $cos(th));
          es = int'(real'(AMP) * $sin(th));
          rq = $sformatf("R%0d", it.tag);
          // R4: arrival cycle
          check(it.due == cyc, "R4 latency", cyc, it.due);
          // R5 / R2 / R3 / R6 by tag: value accuracy
          check(absi(c - ec) <= TOL, {rq, " cos"}, c, ec);
          check(absi(s - es) <= TOL, {rq, " sin"}, s, es);
          // R7: magnitude
          m = $sqrt(real'(c) * real'(c) + real'(s) * real'(s));
          check((m - real'(AMP) <= MAG_TOL) && (real'(AMP) - m <= MAG_TOL),
                "R7 magnitude", int'(m), AMP);
          // R9: bound
          check(absi(c) <= AMP + 4 && absi(s) <= AMP + 4, "R9 bound",
                (absi(c) > absi(s)) ? absi(c) : absi(s), AMP + 4);
          last_c = c;
          last_s = s;
          seen   = 1'b1;
        end
      end else if (seen) begin
        // R8: hold while not valid
        check(int'(cos_w) == last_c, "R8 cos hold", int'(cos_w), last_c);
        check(int'(sin_w) == last_s, "R8 sin hold", int'(sin_w), last_s);
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    check(valid_w == 1'b0, "R1 valid in reset", int'(valid_w), 0);
    check(cos_w == '0, "R1 cos in reset", int'(cos_w), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: after release, nothing enabled yet
    check(valid_w == 1'b0, "R1 valid after reset", int'(valid_w), 0);
    check(cos_w == '0 && sin_w == '0, "R1 outputs after reset",
          int'(cos_w) | int'(sin_w), 0);

    // R6: exact quarter turns
    drive(1'b1, '0, 24'h000000, 6);
    drive(1'b1, '0, 24'h400000, 6);
    drive(1'b1, '0, 24'h800000, 6);
    drive(1'b1, '0, 24'hC00000, 6);

    // R2: continuous accumulation, wraps past 2^24
    for (int i = 0; i < 300; i++) drive(1'b1, 24'h010203, '0, 2);

    // R2: gaps with a changing word while disabled
    for (int i = 0; i < 40; i++) begin
      drive(1'b1, 24'h123457, '0, 2);
      drive(1'b0, 24'hFFFFFF, '0, 2);
    end

    // R3: phase keying on a steady carrier
    for (int i = 0; i < 64; i++)
      drive(1'b1, 24'h040000, PW'((i % 4) * 24'h400000 + (i % 3) * 24'h155555), 3);

    // R9: phases next to quadrant boundaries
    drive(1'b1, '0, 24'hFFFFFF - model_acc + 24'h0, 9);
    drive(1'b1, '0, 24'h3FFFFF - model_acc, 9);
    drive(1'b1, '0, 24'h400001 - model_acc, 9);
    drive(1'b1, '0, 24'h7FFFFF - model_acc, 9);
    drive(1'b1, '0, 24'hBFFFFF - model_acc, 9);
    drive(1'b1, '0, 24'hC00001 - model_acc, 9);

    // R7: fine sweep over more than a full turn
    for (int i = 0; i < 2500; i++) drive(1'b1, 24'h002001, '0, 7);

    // R8: idle, outputs must hold
    for (int i = 0; i < LAT + 8; i++) drive(1'b0, 24'h0ABCDE, '0, 8);

    check(sb.size() == 0, "R4 outstanding samples", sb.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule